// File: doc/BRIEF.md
# Multidrop Address Wake/Doze Controller

This block sits between the character deserializer of a 9-bit multidrop serial receiver and its receive FIFO. Each completed character comes with a flag that marks it as an address or as data. The block compares every address character with the station's own address. Depending on a 2-bit automatic mode, it turns the local receiver on when its own address arrives, off when another station's address arrives, or both. It also decides which characters are written into the receive FIFO.

Recognition keeps running while the receiver is disabled or has just been reset. A station that is asleep can therefore be woken by its own address, and that wake-up takes priority over host disable and reset commands given in the same cycle. A single keep/strip control decides whether an address character that causes a wake or doze action is removed from the data stream or pushed with its address flag. The host can still enable, disable or reset the receiver with one-cycle command pulses.

Top module: `mdw_wake_doze_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rx_enable` and `push_valid` are 0.
- R2: A character is an address character when `char_is_addr` is 1. It matches only when all `DATA_W` bits of `char_data` equal `station_addr`. A difference in any single bit is a mismatch.
- R3: With `auto_mode` = 2'b01 (wake), a matching address character sets `rx_enable` to 1 on the next clock. This happens even if the receiver is disabled, and even if `host_rx_disable` or `host_rx_reset` is high in the same cycle.
- R4: With `auto_mode` = 2'b10 (doze), a non-matching address character clears `rx_enable` on the next clock, even if `host_rx_enable` is high in the same cycle. A matching address leaves the state unchanged.
- R5: With `auto_mode` = 2'b11, both the wake action of R3 and the doze action of R4 apply.
- R6: With `auto_mode` = 2'b00, address characters change nothing automatically. Every character, address or data, is pushed exactly when `rx_enable` is 1.
- R7: In any nonzero mode, an address character that triggers a wake or doze action is pushed if `keep_addr` = 1 and dropped if `keep_addr` = 0. The enable state before the character does not matter.
- R8: In any nonzero mode, an address character that triggers no action is pushed only when `keep_addr` = 1 and `rx_enable` is 1.
- R9: A data character (`char_is_addr` = 0) is pushed only when `rx_enable` is 1. While the receiver is disabled, no data character is pushed.
- R10: With no address action in the same cycle, a `host_rx_enable` pulse sets `rx_enable`, and a `host_rx_disable` or `host_rx_reset` pulse clears it. When an enable and a clear come together, the clear wins.
- R11: A push appears as `push_valid` one clock after `char_valid`, with `push_data` equal to the character and `push_is_addr` equal to its flag. There is no push in a cycle after no character.
- R12: `rx_enable` changes only on the clock after a character or a host command. It holds its value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe for a completed character |
| char_data | input | DATA_W | Character payload |
| char_is_addr | input | 1 | Ninth bit: 1 = address character |
| station_addr | input | DATA_W | This station's address |
| auto_mode | input | 2 | 00 off, 01 wake, 10 doze, 11 both |
| keep_addr | input | 1 | 1 = push address characters that cause an action, 0 = strip them |
| host_rx_enable | input | 1 | Host command pulse: enable receiver |
| host_rx_disable | input | 1 | Host command pulse: disable receiver |
| host_rx_reset | input | 1 | Host command pulse: reset (disable) receiver |
| rx_enable | output | 1 | Receiver enable state |
| push_valid | output | 1 | FIFO write request |
| push_data | output | DATA_W | Data written to the FIFO |
| push_is_addr | output | 1 | Address flag stored with the pushed byte |

## Verification
The bench sweeps every combination of mode, keep bit, prior enable state, character type and match result. A design that used the old enable state to decide pushes for action characters would drop a kept wake address or leak a stripped doze address. It also sends addresses that differ from the station in exactly one bit, which catches a comparator that ignores some bit positions. Same-cycle collisions between address actions and host commands expose a wrong priority, for example a reset that defeats a wake-up. Idle cycles after each state show whether the enable changes or pushes appear without a cause.

// File: rtl/mdw_pkg.sv
`timescale 1ns/1ps
package mdw_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_WAKE = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_BOTH = 2'b11
    } auto_mode_e;

    function automatic logic wake_on(input auto_mode_e m);
        return (m == MODE_WAKE) || (m == MODE_BOTH);
    endfunction

    function automatic logic doze_on(input auto_mode_e m);
        return (m == MODE_DOZE) || (m == MODE_BOTH);
    endfunction

endpackage

// File: rtl/mdw_addr_match.sv
`timescale 1ns/1ps
module mdw_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic              char_valid,
    input  logic              char_is_addr,
    input  logic [DATA_W-1:0] char_data,
    input  logic [DATA_W-1:0] station_addr,
    output logic              addr_seen,
    output logic              addr_match
);
    logic [DATA_W-1:0] bit_eq;

    // per-bit equality, reduced below
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_eq[i] = ~(char_data[i] ^ station_addr[i]);
    end

    assign addr_seen  = char_valid & char_is_addr;
    assign addr_match = &bit_eq;
endmodule

// File: rtl/mdw_action_dec.sv
`timescale 1ns/1ps
module mdw_action_dec
    import mdw_pkg::*;
(
    input  logic       addr_seen,
    input  logic       addr_match,
    input  logic [1:0] auto_mode,
    output logic       auto_on,
    output logic       wake_hit,
    output logic       doze_hit
);
    auto_mode_e mode;

    always_comb begin
        mode     = auto_mode_e'(auto_mode);
        auto_on  = (mode != MODE_OFF);
        wake_hit = addr_seen &  addr_match & wake_on(mode);
        doze_hit = addr_seen & ~addr_match & doze_on(mode);
    end
endmodule

// File: rtl/mdw_push_sel.sv
`timescale 1ns/1ps
module mdw_push_sel (
    input  logic char_valid,
    input  logic char_is_addr,
    input  logic auto_on,
    input  logic action,
    input  logic keep_addr,
    input  logic rx_en_now,
    output logic push_req
);
    always_comb begin
        push_req = 1'b0;
        if (char_valid) begin
            if (!auto_on || !char_is_addr) begin
                push_req = rx_en_now;
            end else if (action) begin
                push_req = keep_addr;
            end else begin
                push_req = keep_addr & rx_en_now;
            end
        end
    end
endmodule

// File: rtl/mdw_wake_doze_ctrl.sv
`timescale 1ns/1ps
module mdw_wake_doze_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_is_addr,
    input  logic [DATA_W-1:0] station_addr,
    input  logic [1:0]        auto_mode,
    input  logic              keep_addr,
    input  logic              host_rx_enable,
    input  logic              host_rx_disable,
    input  logic              host_rx_reset,
    output logic              rx_enable,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_is_addr
);
    typedef struct packed {
        logic              rx_en;
        logic              push_valid;
        logic              push_is_addr;
        logic [DATA_W-1:0] push_data;
    } ctrl_state_t;

    localparam ctrl_state_t STATE_RESET = '0;

    ctrl_state_t st_d, st_q;

    logic addr_seen, addr_match;
    logic auto_on, wake_hit, doze_hit;
    logic push_req;

    mdw_addr_match #(.DATA_W(DATA_W)) u_match (
        .char_valid   (char_valid),
        .char_is_addr (char_is_addr),
        .char_data    (char_data),
        .station_addr (station_addr),
        .addr_seen    (addr_seen),
        .addr_match   (addr_match)
    );

    mdw_action_dec u_dec (
        .addr_seen  (addr_seen),
        .addr_match (addr_match),
        .auto_mode  (auto_mode),
        .auto_on    (auto_on),
        .wake_hit   (wake_hit),
        .doze_hit   (doze_hit)
    );

    mdw_push_sel u_push (
        .char_valid   (char_valid),
        .char_is_addr (char_is_addr),
        .auto_on      (auto_on),
        .action       (wake_hit | doze_hit),
        .keep_addr    (keep_addr),
        .rx_en_now    (st_q.rx_en),
        .push_req     (push_req)
    );

    always_comb begin
        st_d            = st_q;
        st_d.push_valid = push_req;
        if (char_valid) begin
            st_d.push_data    = char_data;
            st_d.push_is_addr = char_is_addr;
        end
        // address actions outrank host commands; clear outranks set
        if (wake_hit) begin
            st_d.rx_en = 1'b1;
        end else if (doze_hit) begin
            st_d.rx_en = 1'b0;
        end else if (host_rx_disable || host_rx_reset) begin
            st_d.rx_en = 1'b0;
        end else if (host_rx_enable) begin
            st_d.rx_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_enable    = st_q.rx_en;
    assign push_valid   = st_q.push_valid;
    assign push_data    = st_q.push_data;
    assign push_is_addr = st_q.push_is_addr;
endmodule

// File: rtl/mdw_wake_doze_ctrl_chk.sv
`timescale 1ns/1ps
module mdw_wake_doze_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic [DATA_W-1:0] char_data,
    input logic              char_is_addr,
    input logic [DATA_W-1:0] station_addr,
    input logic [1:0]        auto_mode,
    input logic              keep_addr,
    input logic              host_rx_enable,
    input logic              host_rx_disable,
    input logic              host_rx_reset,
    input logic              rx_enable,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              push_is_addr
);
    logic is_own;
    assign is_own = (char_data == station_addr);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rx_enable && !push_valid));

    assert_wake_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_is_addr && auto_mode[0] && is_own) |=> rx_enable);

    assert_doze_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_is_addr && auto_mode[1] && !is_own) |=> !rx_enable);

    assert_off_mode_follows_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && auto_mode == 2'b00) |=> (push_valid == $past(rx_enable)));

    assert_strip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_is_addr && auto_mode != 2'b00 && !keep_addr) |=> !push_valid);

    assert_data_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !char_is_addr && !rx_enable) |=> !push_valid);

    assert_push_payload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> (!push_valid ||
                        (push_data == $past(char_data) && push_is_addr == $past(char_is_addr))));

    assert_no_spurious_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |=> !push_valid);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_valid && !host_rx_enable && !host_rx_disable && !host_rx_reset)
        |=> $stable(rx_enable));
endmodule

bind mdw_wake_doze_ctrl mdw_wake_doze_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .char_valid      (char_valid),
    .char_data       (char_data),
    .char_is_addr    (char_is_addr),
    .station_addr    (station_addr),
    .auto_mode       (auto_mode),
    .keep_addr       (keep_addr),
    .host_rx_enable  (host_rx_enable),
    .host_rx_disable (host_rx_disable),
    .host_rx_reset   (host_rx_reset),
    .rx_enable       (rx_enable),
    .push_valid      (push_valid),
    .push_data       (push_data),
    .push_is_addr    (push_is_addr)
);

// File: tb/mdw_wake_doze_ctrl_test.sv
`timescale 1ns/1ps
module mdw_wake_doze_ctrl_test;
    localparam int DW = 8;
    localparam logic [DW-1:0] STATION = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          char_valid = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic          char_is_addr = 1'b0;
    logic [DW-1:0] station_addr = STATION;
    logic [1:0]    auto_mode = 2'b00;
    logic          keep_addr = 1'b0;
    logic          host_rx_enable = 1'b0;
    logic          host_rx_disable = 1'b0;
    logic          host_rx_reset = 1'b0;
    logic          rx_enable, push_valid, push_is_addr;
    logic [DW-1:0] push_data;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mdw_wake_doze_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_is_addr(char_is_addr), .station_addr(station_addr), .auto_mode(auto_mode),
        .keep_addr(keep_addr), .host_rx_enable(host_rx_enable),
        .host_rx_disable(host_rx_disable), .host_rx_reset(host_rx_reset),
        .rx_enable(rx_enable), .push_valid(push_valid), .push_data(push_data),
        .push_is_addr(push_is_addr)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-cycle stimulus, then sample at the following falling edge
    task automatic step(input logic v, input logic [DW-1:0] d, input logic a,
                        input logic en, input logic dis, input logic rs);
        @(negedge clk);
        char_valid = v; char_data = d; char_is_addr = a;
        host_rx_enable = en; host_rx_disable = dis; host_rx_reset = rs;
        @(negedge clk);
        char_valid = 1'b0; char_is_addr = 1'b0;
        host_rx_enable = 1'b0; host_rx_disable = 1'b0; host_rx_reset = 1'b0;
    endtask

    task automatic set_en(input logic e);
        step(1'b0, '0, 1'b0, e, !e, 1'b0);
        chk("R10 host set/clear", {7'b0, rx_enable}, {7'b0, e});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k = 0;
        repeat (3) @(negedge clk);
        chk("R1 rx_enable in reset", {7'b0, rx_enable}, 8'h0);
        chk("R1 push_valid in reset", {7'b0, push_valid}, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_enable after reset", {7'b0, rx_enable}, 8'h0);

        // full sweep: mode x keep x prior enable x flag x match
        for (int m = 0; m < 4; m++) begin
            for (int kp = 0; kp < 2; kp++) begin
                for (int e0 = 0; e0 < 2; e0++) begin
                    for (int fl = 0; fl < 2; fl++) begin
                        for (int mt = 0; mt < 2; mt++) begin
                            logic [DW-1:0] d;
                            logic wake, doze, exp_en, exp_push;
                            string ten, tpu;
                            auto_mode = m[1:0];
                            keep_addr = kp[0];
                            set_en(e0[0]);
                            d = mt[0] ? STATION : (STATION ^ (8'h01 << (k % DW)));
                            k++;
                            wake = fl[0] && mt[0] && m[0];
                            doze = fl[0] && !mt[0] && m[1];
                            exp_en = wake ? 1'b1 : (doze ? 1'b0 : e0[0]);
                            if (m == 0 || fl == 0) exp_push = e0[0];
                            else if (wake || doze)  exp_push = kp[0];
                            else                    exp_push = kp[0] && e0[0];
                            ten = (m == 0) ? "R6 enable" : (m == 1) ? "R3 enable" :
                                  (m == 2) ? "R4 enable" : "R5 enable";
                            tpu = (m == 0) ? "R6 push" : (fl == 0) ? "R9 push" :
                                  (wake || doze) ? "R7 push" : "R8 push";
                            step(1'b1, d, fl[0], 1'b0, 1'b0, 1'b0);
                            chk(ten, {7'b0, rx_enable}, {7'b0, exp_en});
                            chk(tpu, {7'b0, push_valid}, {7'b0, exp_push});
                            if (exp_push) begin
                                chk("R11 push_data", push_data, d);
                                chk("R11 push_is_addr", {7'b0, push_is_addr}, {7'b0, fl[0]});
                            end
                            // idle cycle: no push, enable held
                            step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
                            chk("R11 no push when idle", {7'b0, push_valid}, 8'h0);
                            chk("R12 enable held", {7'b0, rx_enable}, {7'b0, exp_en});
                        end
                    end
                end
            end
        end

        // R2: every single-bit mismatch fails to wake
        auto_mode = 2'b01; keep_addr = 1'b0;
        for (int b = 0; b < DW; b++) begin
            set_en(1'b0);
            step(1'b1, STATION ^ (8'h01 << b), 1'b1, 1'b0, 1'b0, 1'b0);
            chk("R2 one-bit mismatch no wake", {7'b0, rx_enable}, 8'h0);
        end

        // R3: wake overrides same-cycle host disable and reset
        set_en(1'b0);
        step(1'b1, STATION, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R3 wake beats disable/reset", {7'b0, rx_enable}, 8'h1);
        // R4: doze beats same-cycle host enable
        auto_mode = 2'b10;
        set_en(1'b1);
        step(1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R4 doze beats host enable", {7'b0, rx_enable}, 8'h0);
        // R10: clear wins over set; reset pulse clears
        auto_mode = 2'b00;
        set_en(1'b1);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 clear wins over set", {7'b0, rx_enable}, 8'h0);
        set_en(1'b1);
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 reset wins over set", {7'b0, rx_enable}, 8'h0);
        set_en(1'b1);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 reset pulse clears", {7'b0, rx_enable}, 8'h0);
        // R9: data stream while disabled in wake mode, then after wake
        auto_mode = 2'b01; keep_addr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 8'(i * 37), 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R9 data dropped while asleep", {7'b0, push_valid}, 8'h0);
        end
        step(1'b1, STATION, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 stripped wake address", {7'b0, push_valid}, 8'h0);
        step(1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 data pushed after wake", {7'b0, push_valid}, 8'h1);
        chk("R11 data payload", push_data, 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule